// File: doc/BRIEF.md
# Bidirectional Block Move Engine

This block copies a run of bytes from one memory bank to another, one byte at a time, as the two block move instructions of a CPU with 24-bit addresses do. A start strobe loads a 16-bit count, a 16-bit source offset and a 16-bit destination offset, together with a source bank byte and a destination bank byte. A direction select picks between an ascending walk, which starts at the lowest byte of each block, and a descending walk, which starts at the highest byte.

The count holds the number of bytes minus one. The block alternates a read phase and a write phase on a simple synchronous byte memory port, and it steps the two offsets and the count after every write. The move stops when the count steps from zero to all ones. One cycle after the last write, a single-cycle done pulse is issued. At that point the final count, offsets and data bank value are on the outputs.

Each byte is read before it is written. When the source and destination ranges overlap, the result therefore depends on the chosen direction. If the walk runs away from the overlap, the copy is faithful. If it runs into the overlap, a short source pattern is replicated on purpose.

Top module: `blkmove_engine`

## Requirements
- R1: After reset, busy, done, mem_re and mem_we are 0, and cnt_out, src_out, dst_out and dbank_out are all 0.
- R2: A count value c moves exactly c+1 bytes. A count of 0 moves one byte. On completion cnt_out reads FFFF.
- R3: With dir_up=1, both offsets increment by one after each byte, so the final offsets are start+c+1 (mod 2^16).
- R4: With dir_up=0, both offsets decrement by one after each byte, so the final offsets are start-(c+1) (mod 2^16).
- R5: The memory address is {bank, offset}, with the bank in bits 23:16. Offsets wrap inside their bank and never carry into the bank. No byte outside the destination range is written.
- R6: Each byte takes one read cycle (mem_re=1, source address) and then one write cycle (mem_we=1, destination address). mem_re and mem_we are never high together.
- R7: done is a one-cycle pulse in the cycle after the last write, 2(c+1)+1 cycles after the start strobe is sampled. From that cycle onward, dbank_out holds the destination bank.
- R8: The write data equals the byte returned by the read of the same step. Overlapping ranges therefore copy in order: an ascending move whose destination lies 2 above its source replicates the first two source bytes.
- R9: A start strobe that arrives while busy is high has no effect on the move in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled only while idle |
| dir_up | input | 1 | 1 = ascending walk, 0 = descending walk |
| src_bank | input | 8 | Source bank byte |
| dst_bank | input | 8 | Destination bank byte |
| cnt_in | input | 16 | Byte count minus one |
| src_in | input | 16 | Starting source offset |
| dst_in | input | 16 | Starting destination offset |
| mem_addr | output | 24 | Memory byte address |
| mem_re | output | 1 | Read request; data returns on the next cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, registered by the memory |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_out | output | 16 | Current count register |
| src_out | output | 16 | Current source offset |
| dst_out | output | 16 | Current destination offset |
| dbank_out | output | 8 | Data bank value, set to the destination bank on completion |

## Verification
The bench sweeps small counts in both directions with the destination placed from three bytes below to three bytes above the source. These overlaps expose a design that writes before it reads, or one that steps the offsets the wrong way: such a design would smear or skip bytes compared with an in-order golden copy. Single-byte moves catch an off-by-one stop rule, which would move zero or two bytes and leave a count other than FFFF.

Moves that start at offsets FFFE and 0001 catch a carry that leaks into the bank byte, which would show up as stray writes in the neighbouring bank. A start strobe injected mid-move catches an engine that reloads while busy. The cycle at which done appears, and the data bank value at that cycle, are both checked exactly.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
    typedef enum logic [1:0] {
        BM_IDLE = 2'd0,
        BM_RD   = 2'd1,
        BM_WR   = 2'd2,
        BM_FIN  = 2'd3
    } bm_state_e;
endpackage

// File: rtl/blkmove_stepper.sv
// Steps an offset by one in the selected direction, wrapping within W bits.
module blkmove_stepper #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt = up ? (cur + ONE) : (cur - ONE);
    end
endmodule

// File: rtl/blkmove_addr.sv
// Forms the full byte address from bank and offset for the current phase.
module blkmove_addr #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic              wr_phase,
    input  logic [BANK_W-1:0] sbank,
    input  logic [BANK_W-1:0] dbank,
    input  logic [OFF_W-1:0]  soff,
    input  logic [OFF_W-1:0]  doff,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = wr_phase ? {dbank, doff} : {sbank, soff};
    end
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_up,
    input  logic [BANK_W-1:0] src_bank,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [OFF_W-1:0]  cnt_in,
    input  logic [OFF_W-1:0]  src_in,
    input  logic [OFF_W-1:0]  dst_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  cnt_out,
    output logic [OFF_W-1:0]  src_out,
    output logic [OFF_W-1:0]  dst_out,
    output logic [BANK_W-1:0] dbank_out
);
    import blkmove_pkg::*;

    localparam logic [OFF_W-1:0] CNT_ONE = OFF_W'(1);

    typedef struct packed {
        bm_state_e         st;
        logic              up;
        logic [BANK_W-1:0] sbank;
        logic [BANK_W-1:0] tbank;
        logic [BANK_W-1:0] dbr;
        logic [OFF_W-1:0]  cnt;
        logic [OFF_W-1:0]  soff;
        logic [OFF_W-1:0]  doff;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    // Offset steppers: lane 0 is the source offset, lane 1 the destination.
    logic [OFF_W-1:0] off_cur [2];
    logic [OFF_W-1:0] off_nxt [2];

    assign off_cur[0] = ctx_q.soff;
    assign off_cur[1] = ctx_q.doff;

    for (genvar g = 0; g < 2; g++) begin : g_step
        blkmove_stepper #(.W(OFF_W)) step_i (
            .cur (off_cur[g]),
            .up  (ctx_q.up),
            .nxt (off_nxt[g])
        );
    end

    blkmove_addr #(.BANK_W(BANK_W), .OFF_W(OFF_W)) addr_i (
        .wr_phase (ctx_q.st == BM_WR),
        .sbank    (ctx_q.sbank),
        .dbank    (ctx_q.tbank),
        .soff     (ctx_q.soff),
        .doff     (ctx_q.doff),
        .addr     (mem_addr)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            BM_IDLE: begin
                if (start) begin
                    ctx_d.st    = BM_RD;
                    ctx_d.up    = dir_up;
                    ctx_d.sbank = src_bank;
                    ctx_d.tbank = dst_bank;
                    ctx_d.cnt   = cnt_in;
                    ctx_d.soff  = src_in;
                    ctx_d.doff  = dst_in;
                end
            end
            BM_RD: begin
                ctx_d.st = BM_WR;
            end
            BM_WR: begin
                ctx_d.soff = off_nxt[0];
                ctx_d.doff = off_nxt[1];
                ctx_d.cnt  = ctx_q.cnt - CNT_ONE;
                if (ctx_q.cnt == '0) begin
                    ctx_d.st  = BM_FIN;
                    ctx_d.dbr = ctx_q.tbank;
                end else begin
                    ctx_d.st = BM_RD;
                end
            end
            BM_FIN: begin
                ctx_d.st = BM_IDLE;
            end
            default: ctx_d.st = BM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: BM_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_re    = (ctx_q.st == BM_RD);
    assign mem_we    = (ctx_q.st == BM_WR);
    assign mem_wdata = mem_rdata;
    assign busy      = (ctx_q.st != BM_IDLE);
    assign done      = (ctx_q.st == BM_FIN);
    assign cnt_out   = ctx_q.cnt;
    assign src_out   = ctx_q.soff;
    assign dst_out   = ctx_q.doff;
    assign dbank_out = ctx_q.dbr;
endmodule

// File: rtl/blkmove_chk.sv
module blkmove_chk #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [OFF_W-1:0]  cnt_out,
    input logic [BANK_W-1:0] dbank_out,
    input logic [BANK_W-1:0] src_bank,
    input logic [BANK_W-1:0] dst_bank
);
    logic [BANK_W-1:0] seen_s, seen_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_s <= '0;
            seen_d <= '0;
        end else if (start && !busy) begin
            seen_s <= src_bank;
            seen_d <= dst_bank;
        end
    end

    // R6: never both memory strobes in one cycle
    a_r6_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R6: every read is followed by the matching write
    a_r6_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mem_we && !mem_re));

    // R5: read addresses stay in the source bank
    a_r5_src_bank: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_addr[ADDR_W-1:OFF_W] == seen_s));

    // R5: write addresses stay in the destination bank
    a_r5_dst_bank: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == seen_d));

    // R7: done lasts one cycle
    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done comes right after a write
    a_r7_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));

    // R7: data bank output shows the destination bank at completion
    a_r7_dbank: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dbank_out == seen_d));

    // R2: count has wrapped to all ones at completion
    a_r2_cnt_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_out == '1));

    // R1: idle engine issues no memory traffic
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we));
endmodule

bind blkmove_engine blkmove_chk #(.BANK_W(BANK_W), .OFF_W(OFF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .cnt_out   (cnt_out),
    .dbank_out (dbank_out),
    .src_bank  (src_bank),
    .dst_bank  (dst_bank)
);

// File: tb/blkmove_engine_tb_top.sv
`timescale 1ns/1ps
module blkmove_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_up = 1'b0;
    logic [7:0]  src_bank = '0, dst_bank = '0;
    logic [15:0] cnt_in = '0, src_in = '0, dst_in = '0;
    logic [23:0] mem_addr;
    logic        mem_re, mem_we, busy, done;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] cnt_out, src_out, dst_out;
    logic [7:0]  dbank_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    blkmove_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_up(dir_up),
        .src_bank(src_bank), .dst_bank(dst_bank), .cnt_in(cnt_in),
        .src_in(src_in), .dst_in(dst_in), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out),
        .dbank_out(dbank_out)
    );

    // Memory model: untouched bytes hold a value computed from the address.
    logic [7:0] mem  [int unsigned];
    logic [7:0] gold [int unsigned];

    function automatic logic [7:0] fill(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_rd(input logic [23:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return fill(a);
    endfunction

    function automatic logic [7:0] gold_rd(input logic [23:0] a);
        if (gold.exists(int'(a))) return gold[int'(a)];
        return fill(a);
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_rd(mem_addr);
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One move: golden in-order copy computed here, then the DUT run and compared.
    task automatic run_move(input logic up, input logic [7:0] sb, input logic [7:0] db,
                            input logic [15:0] c, input logic [15:0] x, input logic [15:0] y,
                            input logic inject);
        logic [15:0] gx, gy;
        int k;
        mem.delete();
        gold.delete();
        gx = x;
        gy = y;
        for (int i = 0; i <= int'(c); i++) begin
            gold[int'({db, gy})] = gold_rd({sb, gx});
            gx = up ? gx + 16'd1 : gx - 16'd1;
            gy = up ? gy + 16'd1 : gy - 16'd1;
        end
        @(negedge clk);
        dir_up = up; src_bank = sb; dst_bank = db;
        cnt_in = c; src_in = x; dst_in = y;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        k = 1;
        while (!done && k < 200000) begin
            if (inject && k == 3) begin
                // R9: strobe with other values while busy
                start = 1'b1; cnt_in = 16'h0005; src_in = x ^ 16'h00F0;
                dir_up = ~up; dst_bank = db ^ 8'h11;
            end else begin
                start = 1'b0;
            end
            @(posedge clk); #1;
            k++;
        end
        start = 1'b0;
        chk("R7 done cycle", k, 2 * (int'(c) + 1) + 1);
        chk("R2 final count", cnt_out, 16'hFFFF);
        chk(up ? "R3 final src" : "R4 final src", src_out, gx);
        chk(up ? "R3 final dst" : "R4 final dst", dst_out, gy);
        chk("R7 dbank", dbank_out, db);
        chk("R5 write footprint", mem.num(), gold.num());
        foreach (gold[a]) chk("R8 dest byte", mem_rd(a[23:0]), gold[a]);
        @(posedge clk); #1;
        chk("R7 pulse width", done, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_re", mem_re, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 regs", {cnt_out, src_out}, 0);
        chk("R1 dst/dbank", {dst_out, dbank_out}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: descending move of 100h bytes
        run_move(1'b0, 8'h7E, 8'h7E, 16'h00FF, 16'h1100, 16'h1180, 1'b0);
        chk("R4 example src", src_out, 16'h1000);
        chk("R4 example dst", dst_out, 16'h1080);

        // R8/R3: ascending overlap replicates two bytes
        run_move(1'b1, 8'h7E, 8'h7E, 16'h013D, 16'h28C0, 16'h28C2, 1'b0);
        chk("R3 example src", src_out, 16'h29FE);
        chk("R3 example dst", dst_out, 16'h2A00);
        chk("R8 replicate even", mem_rd(24'h7E29FE), fill(24'h7E28C0));
        chk("R8 replicate odd", mem_rd(24'h7E29FF), fill(24'h7E28C1));

        // R2: single byte, across banks
        run_move(1'b1, 8'h03, 8'h40, 16'h0000, 16'h1234, 16'h8001, 1'b0);
        chk("R2 one byte", mem_rd(24'h408001), fill(24'h031234));

        // R5: ascending wrap at top of bank, descending wrap at bottom
        run_move(1'b1, 8'h01, 8'h02, 16'h0003, 16'hFFFE, 16'hFFFD, 1'b0);
        chk("R5 up wrap", mem_rd(24'h020000), fill(24'h010001));
        run_move(1'b0, 8'h05, 8'h06, 16'h0002, 16'h0001, 16'h0000, 1'b0);
        chk("R5 down wrap", mem_rd(24'h06FFFF), fill(24'h050000));

        // R9: start while busy ignored
        run_move(1'b1, 8'h20, 8'h21, 16'h0009, 16'h0100, 16'h0300, 1'b1);
        run_move(1'b0, 8'h22, 8'h22, 16'h0007, 16'h0500, 16'h0502, 1'b1);

        // Sweep: counts, directions and overlaps (R2, R3, R4, R6, R8)
        for (int c = 0; c < 6; c++) begin
            for (int u = 0; u < 2; u++) begin
                for (int sh = -3; sh <= 3; sh++) begin
                    run_move(u[0], 8'h12, 8'h12, 16'(c), 16'h0400, 16'(32'h0400 + sh), 1'b0);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule